// File: doc/BRIEF.md
# Clock Bank Park and Float Controller

This block sits at the output of one bank in a multi-bank clock distribution tree. It takes the free-running bank clock and produces a group of gated clock outputs. Each output has its own polarity selection. While the bank disable input is low, every output follows the bank clock, inverted where its polarity bit asks for it.

When the disable input goes high, a two-bit mode code chooses what the bank does. In float mode the output enables drop at once and the pads are meant to go to high impedance. In park mode the disable passes through a two-flop synchronizer on the bank clock. Each output is then stopped at its rest level: low for a true output, high for an inverted one. The stop and the later restart both happen on the falling edge of the bank clock. That edge is the falling edge of a true output and the rising edge of an inverted one, so no output ever carries a runt pulse. The test mode code keeps the bank running whatever the disable input does.

A main bank uses four outputs and a feedback bank two, set by a parameter.

Top module: `clk_bank_gate`

## Requirements
- R1: While the disable input is low, every output toggles with the bank clock in any mode, and its output enable is high.
- R2: Mode code 2'b00 with the disable input high drops every output enable to 0 at once, with no clock edge needed. The enables return to 1 as soon as the disable input goes low.
- R3: Mode code 2'b01 with the disable input high parks every output while its output enable stays 1. A true output (polarity bit 0) rests at 0 and an inverted output (polarity bit 1) rests at 1.
- R4: In park mode an output is stopped no later than the third rising edge of the bank clock after the disable input goes high. It is still running through the high phase that follows the first of those edges, because the disable input is synchronized first. The bound is well inside six clock cycles.
- R5: No output ever changes level during the low phase of the bank clock, and no output changes within a high phase. While the clock is low a true output reads 0 and an inverted output reads 1, so every pulse is full width.
- R6: Leaving park mirrors entry. After the disable input falls, the outputs stay parked through the next high phase, then resume, and the first high phase after resuming is a full pulse.
- R7: Mode codes 2'b10 and 2'b11 (test) keep all outputs running and enabled whatever the disable input does.
- R8: While running, output i equals the bank clock XOR polarity bit i, and a polarity change takes effect at once.
- R9: After synchronous active-low reset with the disable input low, the outputs run and the enables are 1 from the first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running bank clock |
| rst_n_i | input | 1 | Synchronous active-low reset |
| dis_i | input | 1 | Bank disable, active high |
| mode_i | input | 2 | Disable style: 00 float, 01 park, 1x test |
| inv_sel_i | input | N_OUT | Per-output polarity, 1 = inverted |
| clk_o | output | N_OUT | Gated clock outputs |
| oe_o | output | N_OUT | Per-output drive enable, 0 = high impedance |

## Verification
The bench builds the block with N_OUT = 4 and SYNC_STAGES = 2, the main-bank case. Random four-bit polarity masks mix true and inverted outputs in the same bank, so a park on the wrong edge or at the wrong rest level shows up beside a correct neighbour. With two synchronizer stages the entry and release latency is fixed at a small, exact cycle count. The bench can therefore pin down the last running high phase and the first parked one, and it checks every low and high phase for level changes.

// File: rtl/clk_bank_gate_pkg.sv
// Shared types for the clock bank gate.
// Assumes the three-level mode pin has already been decoded to two bits.
package clk_bank_gate_pkg;
    typedef enum logic [1:0] {
        GATE_FLOAT = 2'b00,
        GATE_PARK  = 2'b01,
        GATE_TEST  = 2'b10,
        GATE_TEST2 = 2'b11
    } gate_mode_e;
endpackage

// File: rtl/bank_dis_sync.sv
// Synchronizer chain that brings the bank disable into the bank clock domain.
// Assumes STAGES >= 2. The chain clears on synchronous active-low reset.
module bank_dis_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic dis_i,
    output logic dis_sync_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw disable through the chain on each rising edge.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) chain_q <= '0;
        else          chain_q <= {chain_q[STAGES-2:0], dis_i};
    end

    assign dis_sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/bank_park_ctrl.sv
// Decides per output whether the clock runs. The run flags change only on the
// falling edge of the bank clock, when every gated output sits at rest level.
// Assumes mode_i is quasi-static with respect to the bank clock.
module bank_park_ctrl
    import clk_bank_gate_pkg::*;
#(
    parameter int N_OUT = 4
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             dis_sync_i,
    input  logic [1:0]       mode_i,
    output logic [N_OUT-1:0] run_o
);
    logic park_req;

    // Park only when the synchronized disable meets park mode.
    always_comb park_req = dis_sync_i && (gate_mode_e'(mode_i) == GATE_PARK);

    // Update run flags on the falling edge so stops and restarts are clean.
    always_ff @(negedge clk_i) begin
        if (!rst_n_i) run_o <= '1;
        else          run_o <= {N_OUT{~park_req}};
    end
endmodule

// File: rtl/clk_out_gate.sv
// One gated output: ANDs the clock with its run flag, then applies polarity.
// A stopped true output rests low and a stopped inverted output rests high.
// Assumes run_i only changes while clk_i is low.
module clk_out_gate (
    input  logic clk_i,
    input  logic run_i,
    input  logic inv_i,
    output logic clk_o
);
    // Gate then invert, so the rest level is fixed by polarity alone.
    always_comb clk_o = (clk_i & run_i) ^ inv_i;
endmodule

// File: rtl/clk_bank_gate.sv
// Top of one clock output bank: synchronizes the disable, parks outputs on a
// clean edge in park mode, and floats them at once in float mode.
// Assumes a free-running clk_i and a mode code that changes rarely.
module clk_bank_gate
    import clk_bank_gate_pkg::*;
#(
    parameter int N_OUT       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             dis_i,
    input  logic [1:0]       mode_i,
    input  logic [N_OUT-1:0] inv_sel_i,
    output logic [N_OUT-1:0] clk_o,
    output logic [N_OUT-1:0] oe_o
);
    localparam int CNT_W = 2;

    logic             dis_sync;
    logic [N_OUT-1:0] run;
    logic             float_now;

    bank_dis_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i      (clk_i),
        .rst_n_i    (rst_n_i),
        .dis_i      (dis_i),
        .dis_sync_o (dis_sync)
    );

    bank_park_ctrl #(.N_OUT(N_OUT)) u_park (
        .clk_i      (clk_i),
        .rst_n_i    (rst_n_i),
        .dis_sync_i (dis_sync),
        .mode_i     (mode_i),
        .run_o      (run)
    );

    for (genvar g = 0; g < N_OUT; g++) begin : g_out
        clk_out_gate u_gate (
            .clk_i (clk_i),
            .run_i (run[g]),
            .inv_i (inv_sel_i[g]),
            .clk_o (clk_o[g])
        );
    end

    // Float path bypasses the synchronizer so high impedance is immediate.
    always_comb float_now = dis_i && (gate_mode_e'(mode_i) == GATE_FLOAT);
    assign oe_o = {N_OUT{~float_now}};

    // Edges seen since reset, so assertions look back only past reset.
    logic [CNT_W-1:0] since_rst;
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)           since_rst <= '0;
        else if (since_rst != '1) since_rst <= since_rst + 1'b1;
    end

    // Test codes never stop the bank.
    assert_test_runs_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (since_rst != '0 && mode_i[1] && $past(mode_i[1])) |-> (run == '1));

    if (SYNC_STAGES == 2) begin : g_lat_chk
        // Park latency: disable seen two edges ago means parked now.
        assert_park_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
            (since_rst >= 2 && $past(dis_i, 2) && mode_i == GATE_PARK
             && $past(mode_i) == GATE_PARK) |-> (run == '0));
        // Park keeps the pads driven.
        assert_park_drives_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
            (since_rst >= 2 && $past(dis_i, 2) && mode_i == GATE_PARK
             && $past(mode_i) == GATE_PARK) |-> (oe_o == '1 && run == '0));
        // A low disable two edges back leaves the bank running.
        assert_enabled_runs_R1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
            (since_rst >= 2 && !$past(dis_i, 2)) |-> (run == '1));
    end
endmodule

// File: tb/sim_clk_bank_gate.sv
`timescale 1ns/100ps
module sim_clk_bank_gate;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         dis = 1'b0;
    logic [1:0]   mode = 2'b01;
    logic [N-1:0] inv = '0;
    logic [N-1:0] co, oe;

    int vec_cnt = 0;
    int err_cnt = 0;
    bit done = 1'b0;

    logic [N-1:0] h1, h2, l1, l2, oe_s;

    clk_bank_gate #(.N_OUT(N), .SYNC_STAGES(2)) u0 (
        .clk_i(clk), .rst_n_i(rst_n), .dis_i(dis), .mode_i(mode),
        .inv_sel_i(inv), .clk_o(co), .oe_o(oe)
    );

    always #10 clk = ~clk;

    function automatic logic [N-1:0] exp_high(logic [N-1:0] p, logic d, logic [1:0] m);
        return (d && m == 2'b01) ? p : ~p;
    endfunction

    function automatic logic [N-1:0] exp_oe(logic d, logic [1:0] m);
        return (d && m == 2'b00) ? '0 : '1;
    endfunction

    task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        vec_cnt++;
        if (act !== exp) begin
            err_cnt++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock cycle: sample both phases, and check for level changes (R5).
    task automatic cycle();
        @(posedge clk);
        #2.5 h1 = co; oe_s = oe;
        #5.0 h2 = co;
        @(negedge clk);
        #2.5 l1 = co;
        #5.0 l2 = co;
        check("R5 high phase steady", h2, h1);
        check("R5 low phase rest level a", l1, inv);
        check("R5 low phase rest level b", l2, inv);
    endtask

    task automatic settle_and_check(string tag);
        repeat (4) cycle();
        check({tag, " high level"}, h1, exp_high(inv, dis, mode));
        check({tag, " enable"}, oe_s, exp_oe(dis, mode));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #15 rst_n = 1'b1;
        // R9: first cycle after reset already running and enabled.
        cycle();
        check("R9 running after reset", h1, ~inv);
        check("R9 enable after reset", oe_s, '1);

        // R8: polarity change applies at once.
        inv = 4'b1010;
        #1 check("R8 immediate polarity", co, inv);
        settle_and_check("R8 mixed polarity");

        // R2: float is immediate, no clock edge between.
        mode = 2'b00;
        dis = 1'b1;
        #1 check("R2 immediate float", oe, '0);
        settle_and_check("R2 float steady");
        dis = 1'b0;
        #1 check("R2 immediate release", oe, '1);

        // R4: park entry latency.
        mode = 2'b01;
        inv = 4'b0110;
        repeat (4) cycle();
        dis = 1'b1;
        cycle();
        check("R4 still running first high phase", h1, ~inv);
        cycle();
        cycle();
        check("R4 parked by third edge", h1, inv);
        check("R3 park keeps enable", oe_s, '1);

        // R6: release mirrors entry, first pulse full width.
        dis = 1'b0;
        cycle();
        check("R6 parked through next high phase", h1, inv);
        cycle();
        cycle();
        check("R6 resumed full pulse a", h1, ~inv);
        check("R6 resumed full pulse b", h2, ~inv);

        // R7: test codes ignore disable.
        for (int m = 2; m < 4; m++) begin
            mode = 2'(m);
            dis = 1'b1;
            settle_and_check("R7 test mode runs");
        end
        dis = 1'b0;
        mode = 2'b01;
        settle_and_check("R1 park mode, disable low");

        // Random mix of all inputs for R1, R2, R3.
        for (int i = 0; i < 300; i++) begin
            mode = 2'($urandom_range(0, 3));
            dis  = 1'($urandom_range(0, 1));
            inv  = N'($urandom);
            if (!dis)              settle_and_check("R1 random enabled");
            else if (mode == 2'b00) settle_and_check("R2 random float");
            else if (mode == 2'b01) settle_and_check("R3 random park");
            else                   settle_and_check("R7 random test");
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            vec_cnt++;
            err_cnt++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
            $finish;
        end
    end
endmodule